// File: doc/BRIEF.md
# Remote Terminal Message Error Handler

This block sits between a serial-bus word decoder and the status and response logic of a remote terminal. It watches each decoded word and sorts problems into one of four outcomes:

- drop the word silently;
- flag a message error and still answer with status;
- flag a message error, abort the transfer and withhold status;
- flag busy and answer with status.

It also raises a one-cycle message-failure interrupt. A watchdog, kept apart from the message logic, cuts the transmitter off if it stays on too long.

A 1 µs tick comes from a clock divider. Both time limits count this tick: the backend handshake limit (default 8 µs) and the transmit watchdog limit (default 668 µs). The response logic reads the two status flags from `sw_flags`. It sends a status word when it sees `send_status`, and it stops any transfer in progress when it sees `abort`.

Top module: `rt_msg_err_handler`

## Requirements
- R1: A command-sync word (`wd_is_cmd`=1) received while `tx_active`=0 with a parity, Manchester or sync error is ignored: no `send_status`, no `abort`, no interrupt, and `sw_flags` unchanged.
- R2: Command fields are: terminal address in bits 15:11, transmit flag in bit 10, word count in bits 4:0. A valid command whose address equals `my_addr` or 31 (broadcast) clears both status flags. A valid command to any other address changes nothing. After reset, `sw_flags` is 0 and every pulse output is low.
- R3: A valid command to this terminal with `illegal_int` or `illegal_ext` high sets the message-error flag (`sw_flags` bit 10) and pulses `send_status`, with no interrupt.
- R4: A failure gives a one-cycle `abort` and a one-cycle `msg_fail_irq`, sets `sw_flags` bit 10, and produces no `send_status` for that message. A broadcast command with bit 10 set is a failure.
- R5: A legal receive command expects its word count of data words, where 0 means 32. `send_status` pulses on the cycle after the last data word, or on the cycle after the command itself for a transmit command. A broadcast message never pulses `send_status`.
- R6: A data word with a parity, Manchester or sync error during reception is a failure.
- R7: During reception, a `rx_gap` pulse before the count is reached is a failure. So is any valid command word.
- R8: While `tx_active`=1, a decoded word with a parity, Manchester or sync error, or that differs from `tx_expect`, is a failure.
- R9: If `bk_req` stays high without `bk_ack` for the handshake limit (BK_TMO_US ticks), that is a failure.
- R10: If `bk_busy` is high at the command or at any point during reception, the busy flag (`sw_flags` bit 3) is set and status is still sent.
- R11: After TX_MAX_US ticks of continuous `tx_active`, `tx_kill` goes high and `msg_fail_irq` pulses once, with no `abort`. `tx_kill` drops on the cycle after `tx_active` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wd_stb | input | 1 | Decoded word valid, one cycle |
| wd_is_cmd | input | 1 | Word carried a command/status sync (1) or a data sync (0) |
| wd_par_err | input | 1 | Parity error on word |
| wd_man_err | input | 1 | Manchester error on word |
| wd_sync_err | input | 1 | Malformed sync on word |
| wd_data | input | 16 | Decoded word |
| rx_gap | input | 1 | Bus went quiet, one cycle |
| my_addr | input | 5 | This terminal's address |
| illegal_int | input | 1 | Internal legality check rejects the command |
| illegal_ext | input | 1 | External legality input rejects the command |
| bk_busy | input | 1 | Backend busy |
| bk_req | input | 1 | Backend handshake pending |
| bk_ack | input | 1 | Backend handshake completed |
| tx_active | input | 1 | Transmitter driving the bus |
| tx_expect | input | 16 | Word the transmitter is sending |
| sw_flags | output | 16 | Status flag bits (bit 10 message error, bit 3 busy) |
| send_status | output | 1 | Pulse: transmit status word |
| abort | output | 1 | Pulse: abort transfer |
| msg_fail_irq | output | 1 | Pulse: message failure interrupt |
| tx_kill | output | 1 | Force transmitter off the bus |

## Verification
The assertions assume that `wd_stb` is a single-cycle strobe and that `rx_gap` and a timed-out `bk_req` never fall in the same cycle as a corrupted command word. They also assume that `tx_active` is low whenever the terminal receives commands. The bench drives every stimulus at the falling edge, strobes words one at a time with an idle cycle between them, and holds `bk_req` and `tx_active` only inside the scenarios that test them. This keeps each observed pulse tied to exactly one cause.

// File: rtl/rt_err_pkg.sv
package rt_err_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RX = 1'b1} msg_state_e;
  localparam logic [4:0] BCAST_ADDR  = 5'd31;
  localparam int         SW_ME_BIT   = 10;
  localparam int         SW_BUSY_BIT = 3;
endpackage

// File: rtl/rt_rst_sync.sv
module rt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/rt_tick_gen.sv
module rt_tick_gen #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int DW = $clog2(DIV + 1);
  logic [DW-1:0] cnt_q, cnt_d;
  logic          tick_d;

  always_comb begin
    tick_d = (cnt_q == DW'(DIV - 1));
    cnt_d  = tick_d ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tick  <= tick_d;
    end
  end
endmodule

// File: rtl/rt_tick_timer.sv
module rt_tick_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic expired,
  output logic fire
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          exp_d, fire_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    exp_d  = expired;
    fire_d = 1'b0;
    cnt_en = run && tick && !expired;
    if (!run) begin
      cnt_d = '0;
      exp_d = 1'b0;
    end else if (cnt_en) begin
      if (cnt_q == CW'(LIMIT - 1)) begin
        exp_d  = 1'b1;
        fire_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      expired <= 1'b0;
      fire    <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      expired <= exp_d;
      fire    <= fire_d;
    end
  end
endmodule

// File: rtl/rt_msg_err_handler.sv
module rt_msg_err_handler
  import rt_err_pkg::*;
#(
  parameter int CLK_PER_US = 50,
  parameter int BK_TMO_US  = 8,
  parameter int TX_MAX_US  = 668
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wd_stb,
  input  logic        wd_is_cmd,
  input  logic        wd_par_err,
  input  logic        wd_man_err,
  input  logic        wd_sync_err,
  input  logic [15:0] wd_data,
  input  logic        rx_gap,
  input  logic [4:0]  my_addr,
  input  logic        illegal_int,
  input  logic        illegal_ext,
  input  logic        bk_busy,
  input  logic        bk_req,
  input  logic        bk_ack,
  input  logic        tx_active,
  input  logic [15:0] tx_expect,
  output logic [15:0] sw_flags,
  output logic        send_status,
  output logic        abort,
  output logic        msg_fail_irq,
  output logic        tx_kill
);
  logic rst_i_n, tick, bk_fire, bk_exp, wd_fire;

  rt_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  rt_tick_gen #(.DIV(CLK_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_i_n), .tick(tick));

  rt_tick_timer #(.LIMIT(BK_TMO_US)) u_bk_tmr (
    .clk(clk), .rst_n(rst_i_n), .run(bk_req && !bk_ack), .tick(tick),
    .expired(bk_exp), .fire(bk_fire));

  rt_tick_timer #(.LIMIT(TX_MAX_US)) u_tx_wd (
    .clk(clk), .rst_n(rst_i_n), .run(tx_active), .tick(tick),
    .expired(tx_kill), .fire(wd_fire));

  // word classification
  logic       wd_bad, rx_evt, cmd_ok, for_me, is_bc, is_tx, echo_fail;
  logic [4:0] c_addr, c_wc;

  always_comb begin
    c_addr    = wd_data[15:11];
    is_tx     = wd_data[10];
    c_wc      = wd_data[4:0];
    wd_bad    = wd_par_err | wd_man_err | wd_sync_err;
    rx_evt    = wd_stb && !tx_active;
    cmd_ok    = rx_evt && wd_is_cmd && !wd_bad;
    is_bc     = (c_addr == BCAST_ADDR);
    for_me    = (c_addr == my_addr) || is_bc;
    echo_fail = wd_stb && tx_active && (wd_bad || (wd_data != tx_expect));
  end

  // message sequencer
  msg_state_e state_q, state_d;
  logic [5:0] cnt_q, cnt_d;
  logic       bc_q, bc_d, me_q, me_d, busy_q, busy_d;
  logic       stat_d, fail, fail_any;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bc_d    = bc_q;
    me_d    = me_q;
    busy_d  = busy_q;
    stat_d  = 1'b0;
    fail    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cmd_ok && for_me) begin
          me_d   = 1'b0;
          busy_d = bk_busy;
          bc_d   = is_bc;
          if (is_bc && is_tx) begin
            fail = 1'b1;
          end else if (illegal_int || illegal_ext) begin
            me_d   = 1'b1;
            stat_d = !is_bc;
          end else if (is_tx) begin
            stat_d = 1'b1;
          end else begin
            state_d = ST_RX;
            cnt_d   = (c_wc == 5'd0) ? 6'd32 : {1'b0, c_wc};
          end
        end
      end
      ST_RX: begin
        if (bk_busy) busy_d = 1'b1;
        if (rx_evt && !wd_is_cmd) begin
          if (wd_bad) begin
            fail = 1'b1;
          end else begin
            cnt_d = cnt_q - 1'b1;
            if (cnt_q == 6'd1) begin
              state_d = ST_IDLE;
              stat_d  = !bc_q;
            end
          end
        end else if (cmd_ok || rx_gap) begin
          fail = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    fail_any = fail || echo_fail || bk_fire;
    if (fail_any) begin
      me_d    = 1'b1;
      stat_d  = 1'b0;
      state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      bc_q         <= 1'b0;
      me_q         <= 1'b0;
      busy_q       <= 1'b0;
      send_status  <= 1'b0;
      abort        <= 1'b0;
      msg_fail_irq <= 1'b0;
    end else begin
      state_q      <= state_d;
      cnt_q        <= cnt_d;
      bc_q         <= bc_d;
      me_q         <= me_d;
      busy_q       <= busy_d;
      send_status  <= stat_d;
      abort        <= fail_any;
      msg_fail_irq <= fail_any || wd_fire;
    end
  end

  always_comb begin
    sw_flags              = '0;
    sw_flags[SW_ME_BIT]   = me_q;
    sw_flags[SW_BUSY_BIT] = busy_q;
  end

  logic unused_ok;
  assign unused_ok = bk_exp;
endmodule

// File: rtl/rt_msg_err_chk.sv
module rt_msg_err_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wd_stb,
  input logic        wd_is_cmd,
  input logic        wd_par_err,
  input logic        wd_man_err,
  input logic        wd_sync_err,
  input logic        rx_gap,
  input logic        bk_req,
  input logic        tx_active,
  input logic [15:0] sw_flags,
  input logic        send_status,
  input logic        abort,
  input logic        msg_fail_irq,
  input logic        tx_kill
);
  AST_ABORT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> msg_fail_irq); // R4
  AST_ABORT_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !send_status); // R4
  AST_ABORT_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> sw_flags[10]); // R4
  AST_BAD_CMD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_stb && wd_is_cmd && !tx_active && !rx_gap && !bk_req &&
     (wd_par_err || wd_man_err || wd_sync_err)) |=> (!send_status && !abort)); // R1
  AST_KILL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |=> !tx_kill); // R11
endmodule

bind rt_msg_err_handler rt_msg_err_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wd_stb(wd_stb), .wd_is_cmd(wd_is_cmd),
  .wd_par_err(wd_par_err), .wd_man_err(wd_man_err), .wd_sync_err(wd_sync_err),
  .rx_gap(rx_gap), .bk_req(bk_req), .tx_active(tx_active), .sw_flags(sw_flags),
  .send_status(send_status), .abort(abort), .msg_fail_irq(msg_fail_irq),
  .tx_kill(tx_kill));

// File: tb/rt_msg_err_handler_tb.sv
module rt_msg_err_handler_tb;
  localparam int DIV = 50;
  localparam int BKT = 8;
  localparam int WDT = 668;
  localparam logic [4:0] ME = 5'd5;

  logic clk = 1'b0;
  logic rst_n;
  logic wd_stb, wd_is_cmd, wd_par_err, wd_man_err, wd_sync_err, rx_gap;
  logic [15:0] wd_data, tx_expect, sw_flags;
  logic [4:0] my_addr;
  logic illegal_int, illegal_ext, bk_busy, bk_req, bk_ack, tx_active;
  logic send_status, abort, msg_fail_irq, tx_kill;
  int n_chk = 0, n_err = 0;
  logic o_st, o_ab, o_irq;

  always #10 clk = ~clk;

  rt_msg_err_handler u_dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cmd(input logic [4:0] a, input logic t, input logic [4:0] wc);
    return {a, t, 5'd1, wc};
  endfunction

  // drive one word, observe pulses on the following cycle
  task automatic word(input logic c, input logic [15:0] d, input logic pe = 0,
                      input logic me = 0, input logic se = 0);
    @(negedge clk);
    wd_stb = 1; wd_is_cmd = c; wd_data = d;
    wd_par_err = pe; wd_man_err = me; wd_sync_err = se;
    @(negedge clk);
    wd_stb = 0; wd_par_err = 0; wd_man_err = 0; wd_sync_err = 0;
    o_st = send_status; o_ab = abort; o_irq = msg_fail_irq;
  endtask

  task automatic gap_pulse();
    @(negedge clk); rx_gap = 1;
    @(negedge clk); rx_gap = 0;
    o_st = send_status; o_ab = abort; o_irq = msg_fail_irq;
  endtask

  task automatic expect_fail(input string req);
    chk(req, {o_ab, o_irq, o_st}, 3'b110);
    chk(req, sw_flags, 16'h0400);
  endtask

  task automatic t_reset();
    chk("R2", sw_flags, 16'h0000);
    chk("R2", {send_status, abort, msg_fail_irq, tx_kill}, 4'b0000);
  endtask

  task automatic t_illegal_and_bad_cmd();
    illegal_ext = 1; word(1, cmd(ME, 1, 0)); illegal_ext = 0;
    chk("R3", {o_st, o_irq, o_ab}, 3'b100);
    chk("R3", sw_flags, 16'h0400);
    illegal_int = 1; word(1, cmd(ME, 0, 2)); illegal_int = 0;
    chk("R3", {o_st, o_irq}, 2'b10);
    word(1, cmd(ME, 1, 0), 1, 0, 0);
    chk("R1", {o_st, o_ab, o_irq}, 3'b000);
    word(1, cmd(ME, 1, 0), 0, 1, 0);
    chk("R1", {o_st, o_ab, o_irq}, 3'b000);
    word(1, cmd(ME, 1, 0), 0, 0, 1);
    chk("R1", {o_st, o_ab, o_irq}, 3'b000);
    chk("R1", sw_flags, 16'h0400);
  endtask

  task automatic t_address();
    word(1, cmd(5'd9, 1, 0));
    chk("R2", {o_st, o_ab}, 2'b00);
    chk("R2", sw_flags, 16'h0400);
    word(1, cmd(ME, 1, 3));
    chk("R5", o_st, 1'b1);
    chk("R2", sw_flags, 16'h0000);
  endtask

  task automatic t_bcast_tx();
    word(1, cmd(5'd31, 1, 1));
    expect_fail("R4");
  endtask

  task automatic t_rx();
    word(1, cmd(ME, 0, 3));
    chk("R5", o_st, 1'b0);
    chk("R2", sw_flags, 16'h0000);
    word(0, 16'h1111); word(0, 16'h2222);
    chk("R5", o_st, 1'b0);
    word(0, 16'h3333);
    chk("R5", {o_st, o_ab}, 2'b10);
    word(1, cmd(ME, 0, 0));
    for (int i = 0; i < 31; i++) word(0, 16'(i));
    chk("R5", o_st, 1'b0);
    word(0, 16'hABCD);
    chk("R5", {o_st, o_ab}, 2'b10);
    word(1, cmd(5'd31, 0, 2));
    word(0, 16'h1); word(0, 16'h2);
    chk("R5", {o_st, o_ab, o_irq}, 3'b000);
    chk("R5", sw_flags, 16'h0000);
  endtask

  task automatic t_data_err();
    word(1, cmd(ME, 0, 4));
    word(0, 16'h1);
    word(0, 16'h2, 1, 0, 0);
    expect_fail("R6");
    word(0, 16'h3);
    chk("R6", {o_st, o_ab}, 2'b00);
    word(1, cmd(ME, 0, 2));
    word(0, 16'h2, 0, 0, 1);
    expect_fail("R6");
  endtask

  task automatic t_gap();
    word(1, cmd(ME, 0, 3));
    word(0, 16'h1);
    gap_pulse();
    expect_fail("R7");
    word(1, cmd(ME, 0, 3));
    word(1, cmd(ME, 1, 1));
    expect_fail("R7");
  endtask

  task automatic t_echo();
    word(1, cmd(ME, 1, 0));
    @(negedge clk); tx_active = 1; tx_expect = 16'h5A5A;
    word(1, 16'h5A5A);
    chk("R8", {o_ab, o_irq}, 2'b00);
    word(0, 16'h5A5B);
    expect_fail("R8");
    word(1, cmd(ME, 1, 0));
    @(negedge clk); tx_active = 1;
    word(0, 16'h5A5A, 0, 1, 0);
    expect_fail("R8");
    @(negedge clk); tx_active = 0;
  endtask

  task automatic t_bk();
    int cyc = 0;
    logic ab = 0;
    word(1, cmd(ME, 1, 0));
    @(negedge clk); bk_req = 1;
    while (!msg_fail_irq && cyc < (BKT + 2) * DIV) begin
      @(negedge clk); cyc++;
    end
    ab = abort;
    chk("R9", 16'(cyc >= (BKT - 1) * DIV && cyc <= BKT * DIV + 5), 16'd1);
    chk("R9", {ab, send_status}, 2'b10);
    chk("R9", sw_flags, 16'h0400);
    bk_req = 0;
    word(1, cmd(ME, 1, 0));
    @(negedge clk); bk_req = 1;
    cyc = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (msg_fail_irq) cyc++; end
    bk_ack = 1;
    for (int i = 0; i < (BKT + 2) * DIV; i++) begin @(negedge clk); if (msg_fail_irq) cyc++; end
    bk_req = 0; bk_ack = 0;
    chk("R9", 16'(cyc), 16'd0);
  endtask

  task automatic t_busy();
    bk_busy = 1; word(1, cmd(ME, 1, 0)); bk_busy = 0;
    chk("R10", o_st, 1'b1);
    chk("R10", sw_flags, 16'h0008);
    word(1, cmd(ME, 0, 2));
    chk("R10", sw_flags, 16'h0000);
    @(negedge clk); bk_busy = 1; @(negedge clk); bk_busy = 0;
    word(0, 16'h1); word(0, 16'h2);
    chk("R10", {o_st, o_ab}, 2'b10);
    chk("R10", sw_flags, 16'h0008);
  endtask

  task automatic t_watchdog();
    int cyc = 0;
    logic ab;
    @(negedge clk); tx_active = 1;
    while (!msg_fail_irq && cyc < (WDT + 2) * DIV) begin
      @(negedge clk); cyc++;
    end
    ab = abort;
    chk("R11", 16'(cyc >= (WDT - 1) * DIV && cyc <= WDT * DIV + 5), 16'd1);
    chk("R11", {tx_kill, ab}, 2'b10);
    @(negedge clk);
    chk("R11", msg_fail_irq, 1'b0);
    tx_active = 0;
    @(negedge clk);
    chk("R11", tx_kill, 1'b0);
  endtask

  initial begin
    rst_n = 0; wd_stb = 0; wd_is_cmd = 0; wd_par_err = 0; wd_man_err = 0;
    wd_sync_err = 0; wd_data = '0; rx_gap = 0; my_addr = ME; illegal_int = 0;
    illegal_ext = 0; bk_busy = 0; bk_req = 0; bk_ack = 0; tx_active = 0;
    tx_expect = '0; o_st = 0; o_ab = 0; o_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_illegal_and_bad_cmd();
    t_address();
    t_bcast_tx();
    t_rx();
    t_data_err();
    t_gap();
    t_echo();
    t_bk();
    t_busy();
    t_watchdog();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule